// File: doc/BRIEF.md
# Bus Controller Register Block with Set and Clear Aliases

This block holds the software-visible state of a serial bus controller: a command word, a second control word that carries eight event status flags with their interrupt enables, three timing words, a read-only status word and a 32-bit data word. A bus engine and a timing generator elsewhere on the chip read its outputs. Software reaches it through a simple single-cycle write port and a combinational read port.

Each of the two control words answers at three addresses. A write to the base address replaces the stored value. A write to base + 4 ORs the written ones into it. A write to base + 8 clears the bits written as ones. This lets software change single bits without a read-modify-write sequence. Hardware event pulses set status flags in the same cycle as they arrive, and the single interrupt line is raised whenever a set flag has its enable bit set.

A soft reset bit in the command word returns every register to its default. A two-state machine controls the sequence. `ST_ACTIVE` is normal operation. The transition `srst_req` (a write with bit 31 set) leads to `ST_SRST`, a one-cycle recovery state in which writes and events are ignored. The transition `srst_done` always returns to `ST_ACTIVE` on the next cycle.

Top module: `sar_ctrl_regs`

## Requirements
- R1: A write to 0x00 stores bits 30:0 of the command word (bit 31 always reads 0); a write to 0x40 stores bits 15:0 of the second control word, whose bits 31:16 always read 0.
- R2: A write to 0x04 or 0x44 ORs the write data into the command word or the second control word.
- R3: A write to 0x08 or 0x48 clears, in the command word or the second control word, each bit that is 1 in the write data.
- R4: Each one-cycle pulse on `evt_pulse[i]` sets bit i (0 to 7) of the second control word at the next edge. If a clear hits that bit in the same cycle, the bit stays set.
- R5: A pulse on `nak_pulse` sets bit 28 of the status word at 0x50. A write of bit 28 to 0x44 clears it, and a pulse in the same cycle wins. Bit 28 of the second control word itself reads 0.
- R6: The status word at 0x50 shows `bus_busy` live at bit 11 and `clkgen_busy` live at bit 10. All its other bits except bit 28 read 0, and writes to 0x50 have no effect.
- R7: The timing words at 0x10, 0x20 and 0x30 and the data word at 0x60 take plain writes and reset to `TIM_RST` and 0. Any unmapped address reads 0.
- R8: Each alias address (0x04, 0x08, 0x44, 0x48) reads back the current value of its register.
- R9: `irq` is 1 exactly when some bit i in 0..7 of the second control word is set together with its enable bit i+8.
- R10: A write with bit 31 set to 0x00 or 0x04 returns every register to its default at that edge, overriding events in the same cycle. The machine then enters `ST_SRST`.
- R11: In `ST_SRST` writes and event pulses are ignored. The next cycle is always `ST_ACTIVE`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe, one write per cycle |
| addr | input | 8 | Byte address for write and read |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Combinational read data at `addr` |
| evt_pulse | input | 8 | Hardware event pulses for status flags 0..7 |
| nak_pulse | input | 1 | Pulse that latches the no-acknowledge flag |
| bus_busy | input | 1 | Live bus busy indication |
| clkgen_busy | input | 1 | Live clock generator busy indication |
| cmd_q | output | 32 | Current command word |
| tim0_q | output | 32 | First timing word |
| tim1_q | output | 32 | Second timing word |
| tim2_q | output | 32 | Third timing word |
| data_q | output | 32 | Data word |
| irq | output | 1 | Combined interrupt line |

## Verification
The bench builds the block with three distinct non-zero `TIM_RST` values (0x00A00056, 0x00B00034, 0x00C00012). With these, a timing word left at its reset value can be told apart from one cleared to zero or from one another. A soft reset that failed to reload the defaults, or reloaded them into the wrong word, becomes visible at the read port. The other widths are fixed by the address map, so their defaults bring all flags, enables and aliases into play.

// File: rtl/sar_pkg.sv
package sar_pkg;
    localparam int DATA_W    = 32;
    localparam int ADDR_W    = 8;
    localparam int NUM_SRC   = 8;
    localparam int EN_SHIFT  = 8;
    localparam int BIT_SRST  = 31;
    localparam int BIT_NAK   = 28;
    localparam int BIT_BBUSY = 11;
    localparam int BIT_CBUSY = 10;

    localparam logic [ADDR_W-1:0] OFS_CMD    = 8'h00;
    localparam logic [ADDR_W-1:0] OFS_IRQ    = 8'h40;
    localparam logic [ADDR_W-1:0] ALIAS_SET  = 8'h04;
    localparam logic [ADDR_W-1:0] ALIAS_CLR  = 8'h08;
    localparam logic [ADDR_W-1:0] OFS_TIM0   = 8'h10;
    localparam logic [ADDR_W-1:0] TIM_STRIDE = 8'h10;
    localparam logic [ADDR_W-1:0] OFS_STAT   = 8'h50;
    localparam logic [ADDR_W-1:0] OFS_DATA   = 8'h60;

    typedef enum logic {ST_ACTIVE, ST_SRST} srst_state_e;

    typedef struct packed {
        logic plain;
        logic set;
        logic clr;
    } wr_kind_t;
endpackage

// File: rtl/sar_alias_reg.sv
module sar_alias_reg
    import sar_pkg::*;
#(
    parameter int          W       = 32,
    parameter logic [W-1:0] RST_VAL = '0,
    parameter logic [W-1:0] KEEP    = '1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         flush,
    input  wr_kind_t     wk,
    input  logic [W-1:0] wdata,
    input  logic [W-1:0] hw_set,
    output logic [W-1:0] q
);
    logic [W-1:0] nxt;

    always_comb begin
        nxt = q;
        if (wk.plain) nxt = wdata;
        if (wk.set)   nxt = nxt | wdata;
        if (wk.clr)   nxt = nxt & ~wdata;
        nxt = (nxt | hw_set) & KEEP;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     q <= RST_VAL;
        else if (flush) q <= RST_VAL;
        else            q <= nxt;
    end

    // R1: plain write replaces the stored bits
    a_r1_plain: assert property (@(posedge clk) disable iff (!rst_n)
        (wk.plain && !flush) |=> q == (($past(wdata) | $past(hw_set)) & KEEP));
    // R2: set alias raises every written one
    a_r2_set: assert property (@(posedge clk) disable iff (!rst_n)
        (wk.set && !flush) |=> (q & $past(wdata & KEEP)) == $past(wdata & KEEP));
    // R3: clear alias drops written ones unless hardware sets them
    a_r3_clr: assert property (@(posedge clk) disable iff (!rst_n)
        (wk.clr && !flush) |=> (q & $past(wdata & ~hw_set & KEEP)) == '0);
    // R4: a hardware set always lands
    a_r4_hw_wins: assert property (@(posedge clk) disable iff (!rst_n)
        ((hw_set != '0) && !flush) |=> (q & $past(hw_set & KEEP)) == $past(hw_set & KEEP));
endmodule

// File: rtl/sar_irq_merge.sv
module sar_irq_merge #(
    parameter int N = 8
) (
    input  logic [N-1:0] flags,
    input  logic [N-1:0] enables,
    output logic         irq
);
    assign irq = |(flags & enables);
endmodule

// File: rtl/sar_ctrl_regs.sv
module sar_ctrl_regs
    import sar_pkg::*;
#(
    parameter int NUM_TIM = 3,
    parameter logic [NUM_TIM-1:0][DATA_W-1:0] TIM_RST =
        {32'h0030_0040, 32'h00F0_0030, 32'h0078_0030}
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    input  logic [NUM_SRC-1:0] evt_pulse,
    input  logic              nak_pulse,
    input  logic              bus_busy,
    input  logic              clkgen_busy,
    output logic [DATA_W-1:0] cmd_q,
    output logic [DATA_W-1:0] tim0_q,
    output logic [DATA_W-1:0] tim1_q,
    output logic [DATA_W-1:0] tim2_q,
    output logic [DATA_W-1:0] data_q,
    output logic              irq
);
    localparam int NUM_CTL = 2;
    localparam logic [NUM_CTL-1:0][ADDR_W-1:0] CTL_BASE = {OFS_IRQ, OFS_CMD};
    localparam logic [NUM_CTL-1:0][DATA_W-1:0] CTL_KEEP =
        {32'h0000_FFFF, 32'h7FFF_FFFF};

    function automatic logic [ADDR_W-1:0] tim_addr(input int idx);
        return ADDR_W'(int'(OFS_TIM0) + idx * int'(TIM_STRIDE));
    endfunction

    srst_state_e state_q, state_d;
    logic        wr_ok, srst_req, nak_g, nak_q;
    logic [NUM_SRC-1:0]               evt_g;
    logic [NUM_CTL-1:0][DATA_W-1:0]   ctl_q, ctl_hw;
    logic [NUM_TIM-1:0][DATA_W-1:0]   tim_q;
    logic [DATA_W-1:0]                stat_w;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_ACTIVE;
        else        state_q <= state_d;
    end

    // next state: srst_req enters recovery, srst_done leaves it
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_ACTIVE: if (srst_req) state_d = ST_SRST;
            ST_SRST:   state_d = ST_ACTIVE;
            default:   state_d = ST_ACTIVE;
        endcase
    end

    // outputs of the machine: what is accepted this cycle
    always_comb begin
        wr_ok    = wr_en && (state_q == ST_ACTIVE);
        srst_req = wr_ok && wdata[BIT_SRST] &&
                   ((addr == OFS_CMD) || (addr == (OFS_CMD | ALIAS_SET)));
        evt_g    = (state_q == ST_ACTIVE) ? evt_pulse : '0;
        nak_g    = nak_pulse && (state_q == ST_ACTIVE);
    end

    assign ctl_hw[0] = '0;
    assign ctl_hw[1] = {{(DATA_W-NUM_SRC){1'b0}}, evt_g};

    for (genvar k = 0; k < NUM_CTL; k++) begin : g_ctl
        wr_kind_t wk;
        assign wk.plain = wr_ok && (addr == CTL_BASE[k]);
        assign wk.set   = wr_ok && (addr == (CTL_BASE[k] | ALIAS_SET));
        assign wk.clr   = wr_ok && (addr == (CTL_BASE[k] | ALIAS_CLR));
        sar_alias_reg #(
            .W       (DATA_W),
            .RST_VAL ('0),
            .KEEP    (CTL_KEEP[k])
        ) i_reg (
            .clk    (clk),
            .rst_n  (rst_n),
            .flush  (srst_req),
            .wk     (wk),
            .wdata  (wdata),
            .hw_set (ctl_hw[k]),
            .q      (ctl_q[k])
        );
    end

    for (genvar i = 0; i < NUM_TIM; i++) begin : g_tim
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                          tim_q[i] <= TIM_RST[i];
            else if (srst_req)                   tim_q[i] <= TIM_RST[i];
            else if (wr_ok && addr == tim_addr(i)) tim_q[i] <= wdata;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                          data_q <= '0;
        else if (srst_req)                   data_q <= '0;
        else if (wr_ok && addr == OFS_DATA)  data_q <= wdata;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)         nak_q <= 1'b0;
        else if (srst_req)  nak_q <= 1'b0;
        else if (nak_g)     nak_q <= 1'b1;
        else if (wr_ok && addr == (OFS_IRQ | ALIAS_SET) && wdata[BIT_NAK])
                            nak_q <= 1'b0;
    end

    always_comb begin
        stat_w            = '0;
        stat_w[BIT_NAK]   = nak_q;
        stat_w[BIT_BBUSY] = bus_busy;
        stat_w[BIT_CBUSY] = clkgen_busy;
    end

    always_comb begin
        rdata = '0;
        for (int k = 0; k < NUM_CTL; k++)
            if (addr == CTL_BASE[k] || addr == (CTL_BASE[k] | ALIAS_SET) ||
                addr == (CTL_BASE[k] | ALIAS_CLR))
                rdata = ctl_q[k];
        for (int i = 0; i < NUM_TIM; i++)
            if (addr == tim_addr(i)) rdata = tim_q[i];
        if (addr == OFS_STAT) rdata = stat_w;
        if (addr == OFS_DATA) rdata = data_q;
    end

    sar_irq_merge #(.N(NUM_SRC)) i_irq (
        .flags   (ctl_q[1][NUM_SRC-1:0]),
        .enables (ctl_q[1][EN_SHIFT+NUM_SRC-1:EN_SHIFT]),
        .irq     (irq)
    );

    assign cmd_q  = ctl_q[0];
    assign tim0_q = tim_q[0];
    assign tim1_q = tim_q[1];
    assign tim2_q = tim_q[2];

    // R10: soft reset reloads defaults and enters recovery
    a_r10_soft_reset: assert property (@(posedge clk) disable iff (!rst_n)
        srst_req |=> (state_q == ST_SRST) && (cmd_q == '0) && (ctl_q[1] == '0)
                     && (tim_q == TIM_RST) && (data_q == '0) && !nak_q);
    // R11: recovery lasts one cycle
    a_r11_recover: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_SRST) |=> (state_q == ST_ACTIVE));
    // R11: nothing changes during recovery
    a_r11_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_SRST) |=> ($stable(ctl_q) && $stable(tim_q) && $stable(data_q)));
    // R5: no-acknowledge pulse latches
    a_r5_nak_set: assert property (@(posedge clk) disable iff (!rst_n)
        (nak_pulse && state_q == ST_ACTIVE && !srst_req) |=> nak_q);
    // R9: no enabled flag means no interrupt
    a_r9_irq_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        ((ctl_q[1][7:0] & ctl_q[1][15:8]) == '0) |-> !irq);
endmodule

// File: tb/test_sar_ctrl_regs.sv
module test_sar_ctrl_regs;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [7:0]  addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic [7:0]  evt_pulse = '0;
    logic        nak_pulse = 1'b0;
    logic        bus_busy = 1'b0;
    logic        clkgen_busy = 1'b0;
    logic [31:0] cmd_q, tim0_q, tim1_q, tim2_q, data_q;
    logic        irq;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    localparam logic [31:0] T0 = 32'h00A0_0056;
    localparam logic [31:0] T1 = 32'h00B0_0034;
    localparam logic [31:0] T2 = 32'h00C0_0012;

    always #10 clk = ~clk;

    sar_ctrl_regs #(.NUM_TIM(3), .TIM_RST({T2, T1, T0})) i_sar_ctrl_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
        .rdata(rdata), .evt_pulse(evt_pulse), .nak_pulse(nak_pulse),
        .bus_busy(bus_busy), .clkgen_busy(clkgen_busy), .cmd_q(cmd_q),
        .tim0_q(tim0_q), .tim1_q(tim1_q), .tim2_q(tim2_q), .data_q(data_q),
        .irq(irq)
    );

    typedef struct packed {
        logic        wr;
        logic [7:0]  a;
        logic [31:0] d;
        logic [7:0]  ev;
        logic [7:0]  ra;
        logic [31:0] exp;
    } vec_t;

    localparam int NV = 12;
    localparam vec_t VEC [0:NV-1] = '{
        '{1'b1, 8'h00, 32'h0012_3456, 8'h00, 8'h00, 32'h0012_3456}, // R1
        '{1'b1, 8'h04, 32'h0300_0000, 8'h00, 8'h04, 32'h0312_3456}, // R2 R8
        '{1'b1, 8'h08, 32'h0000_0456, 8'h00, 8'h08, 32'h0312_3000}, // R3 R8
        '{1'b1, 8'h40, 32'h0000_2300, 8'h00, 8'h40, 32'h0000_2300}, // R1
        '{1'b1, 8'h44, 32'h0000_0005, 8'h00, 8'h48, 32'h0000_2305}, // R2 R8
        '{1'b1, 8'h48, 32'h0000_0001, 8'h01, 8'h40, 32'h0000_2305}, // R4
        '{1'b1, 8'h48, 32'h0000_0004, 8'h00, 8'h44, 32'h0000_2301}, // R3
        '{1'b1, 8'h10, 32'hAAAA_5555, 8'h00, 8'h10, 32'hAAAA_5555}, // R7
        '{1'b1, 8'h20, 32'h1234_5678, 8'h00, 8'h20, 32'h1234_5678}, // R7
        '{1'b1, 8'h30, 32'h0BAD_F00D, 8'h00, 8'h30, 32'h0BAD_F00D}, // R7
        '{1'b1, 8'h60, 32'hDEAD_BEEF, 8'h00, 8'h60, 32'hDEAD_BEEF}, // R7
        '{1'b0, 8'h00, 32'h0000_0000, 8'h80, 8'h40, 32'h0000_2381}  // R4
    };

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // drive at negedge, latch at posedge, read back shortly after
    task automatic step(input logic wr, input logic [7:0] a, input logic [31:0] d,
                        input logic [7:0] ev, input logic nk,
                        input logic [7:0] ra, input logic [31:0] exp, input string tag);
        @(negedge clk);
        wr_en = wr; addr = a; wdata = d; evt_pulse = ev; nak_pulse = nk;
        @(posedge clk);
        #2;
        wr_en = 1'b0; evt_pulse = '0; nak_pulse = 1'b0; addr = ra;
        #3;
        chk(tag, rdata, exp);
    endtask

    task automatic rd(input logic [7:0] a, input logic [31:0] exp, input string tag);
        @(negedge clk);
        addr = a;
        #2;
        chk(tag, rdata, exp);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // reset state
        rd(8'h00, 32'h0, "R1 reset cmd");
        rd(8'h40, 32'h0, "R1 reset ctrl1");
        rd(8'h10, T0, "R7 reset tim0");
        rd(8'h20, T1, "R7 reset tim1");
        rd(8'h30, T2, "R7 reset tim2");
        rd(8'h50, 32'h0, "R6 reset status");
        chk("R9 reset irq", {31'b0, irq}, 32'h0);

        for (int v = 0; v < NV; v++)
            step(VEC[v].wr, VEC[v].a, VEC[v].d, VEC[v].ev, 1'b0,
                 VEC[v].ra, VEC[v].exp, $sformatf("table R1-vector %0d", v));
        chk("R1 cmd_q port", cmd_q, 32'h0312_3000);
        chk("R7 tim1_q port", tim1_q, 32'h1234_5678);

        // R9 interrupt merge
        chk("R9 enabled flag raises irq", {31'b0, irq}, 32'h1);
        step(1'b1, 8'h48, 32'h1, 8'h0, 1'b0, 8'h40, 32'h0000_2380, "R3 clear flag0");
        chk("R9 unenabled flag keeps irq low", {31'b0, irq}, 32'h0);
        step(1'b1, 8'h44, 32'h8000, 8'h0, 1'b0, 8'h44, 32'h0000_A380, "R2 enable bit15");
        chk("R9 enable of flag7 raises irq", {31'b0, irq}, 32'h1);

        // R5 no-acknowledge latch
        step(1'b0, 8'h00, 32'h0, 8'h0, 1'b1, 8'h50, 32'h1000_0000, "R5 nak latched");
        step(1'b1, 8'h44, 32'h1000_0000, 8'h0, 1'b1, 8'h50, 32'h1000_0000, "R5 pulse beats clear");
        step(1'b1, 8'h44, 32'h1000_0000, 8'h0, 1'b0, 8'h50, 32'h0, "R5 nak cleared");
        rd(8'h44, 32'h0000_A380, "R5 ctrl1 bit28 reads 0");

        // R6 status word
        bus_busy = 1'b1;
        step(1'b1, 8'h50, 32'hFFFF_FFFF, 8'h0, 1'b0, 8'h50, 32'h0000_0800, "R6 write ignored, bus busy");
        bus_busy = 1'b0; clkgen_busy = 1'b1;
        rd(8'h50, 32'h0000_0400, "R6 clkgen busy");
        clkgen_busy = 1'b0;

        step(1'b1, 8'h40, 32'hFFFF_0000, 8'h0, 1'b0, 8'h40, 32'h0, "R1 ctrl1 upper bits dropped");
        chk("R9 irq low after plain clear", {31'b0, irq}, 32'h0);
        rd(8'h7C, 32'h0, "R7 unmapped reads 0");

        // R10 / R11 soft reset
        step(1'b0, 8'h00, 32'h0, 8'h0, 1'b1, 8'h50, 32'h1000_0000, "R5 nak before soft reset");
        step(1'b1, 8'h04, 32'h8000_0001, 8'hFF, 1'b0, 8'h00, 32'h0, "R10 cmd to default");
        step(1'b1, 8'h00, 32'h0000_0055, 8'h01, 1'b1, 8'h00, 32'h0, "R11 write ignored in recovery");
        rd(8'h40, 32'h0, "R11 events ignored, R10 ctrl1 default");
        rd(8'h10, T0, "R10 tim0 reloaded");
        rd(8'h60, 32'h0, "R10 data cleared");
        rd(8'h50, 32'h0, "R10 nak cleared, R11 nak ignored");
        chk("R10 tim0_q port", tim0_q, T0);
        step(1'b1, 8'h00, 32'h0000_0055, 8'h0, 1'b0, 8'h08, 32'h0000_0055, "R11 back to active");

        if (!done) begin
            done = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1;
            checks++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end
endmodule